// File: doc/BRIEF.md
# Windowed Register File with Spill and Fill Traps

This block is the architectural register file of a processor pipeline. It keeps thirty-two visible registers. Eight are globals held in fixed storage, and twenty-four are mapped onto a larger circular physical file through a window pointer. A procedure call (save) moves the pointer one window down, 16 physical entries. The callee then gets fresh locals, and the caller's outgoing registers appear as the callee's incoming registers without any copy. A return (restore) moves the pointer back up, and the caller's view reappears intact.

Two combinational read ports and one clocked write port are addressed by 5-bit architectural indices. A small controller counts the free windows. When a save would reuse a window that still holds live caller data, the controller raises an overflow trap request and does not perform the save. When a restore would return into a window that is no longer resident, it raises an underflow trap request. An external handler moves the window contents to or from memory and ends the trap with a spill-done or fill-done strobe. The instruction stream then reissues the trapped operation.

The controller has three states. `ST_RUN` is normal operation. `ST_OVF_WAIT` holds a pending overflow request, and `ST_UNF_WAIT` holds a pending underflow request. It has four transitions:
- ST_RUN to ST_OVF_WAIT on a save when no window is free.
- ST_OVF_WAIT to ST_RUN on spill-done.
- ST_RUN to ST_UNF_WAIT on a restore when the caller window is not resident.
- ST_UNF_WAIT to ST_RUN on fill-done.

Top module: `rwin_regfile`

## Requirements
- R1: Architectural index 0–7 selects the globals, which read the same in every window. Index a in 8–31 selects physical entry (16·win_ptr + a − 8) mod NPHYS. This places the outgoing registers at 8–15, the locals at 16–23 and the incoming registers at 24–31.
- R2: Index 0 always reads zero on both ports, and a write to index 0 changes nothing.
- R3: A save in ST_RUN with at least one free window takes effect at the next clock edge. It decrements win_ptr by one, modulo NPHYS/16, and the new incoming registers 24–31 read the values the caller had in 8–15.
- R4: A restore in ST_RUN whose caller window is resident increments win_ptr by one, modulo NPHYS/16. The caller's locals and outgoing registers read back unchanged.
- R5: A save in ST_RUN with no free window leaves win_ptr unchanged and sets ovf_trap from the next cycle on.
- R6: While a trap is pending, the following are ignored, and win_ptr and all register contents hold: writes, saves, restores, and the done strobe of the other kind. spill-done in ST_OVF_WAIT clears ovf_trap at the next edge and frees exactly one window.
- R7: A restore in ST_RUN when only the current window is resident leaves win_ptr unchanged and sets unf_trap. fill-done in ST_UNF_WAIT clears unf_trap and makes the caller window resident.
- R8: A write takes effect at the clock edge. A read of the same entry in that cycle returns the old value, and the two read ports are independent.
- R9: After reset, win_ptr is 0, both trap requests are low, every register reads zero, and NPHYS/16 − 2 windows are free.
- R10: When save and restore are requested in the same cycle, only the save is acted on.
- R11: A spill-done or fill-done strobe in ST_RUN has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_a_idx | input | 5 | Architectural index, read port A |
| rd_a_data | output | DW | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural index, read port B |
| rd_b_data | output | DW | Read data, port B (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Architectural index for the write |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Call: move to the next lower window |
| restore_req | input | 1 | Return: move to the next higher window |
| spill_done | input | 1 | Handler has spilled the oldest window |
| fill_done | input | 1 | Handler has filled the caller window |
| win_ptr | output | log2(NPHYS/16) | Current window number |
| ovf_trap | output | 1 | Overflow trap request pending |
| unf_trap | output | 1 | Underflow trap request pending |

## Verification
The assertions check several behaviours on every cycle:
- index 0 reads zero on both ports;
- the two trap requests are never raised together;
- each successful save or restore moves the pointer by exactly one window;
- a save or restore that meets the free-count limit raises its trap and holds the pointer;
- a pending trap holds until its own done strobe, then clears.

The bench's scenarios show the rest, because it takes a reference copy of the storage to judge it:
- the data path itself, with the aliasing of caller outputs onto callee inputs and the survival of the caller's locals across a call and return;
- the old value returned by a read in the same cycle as a write;
- the fact that writes made while a trap is pending do not land.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_OVF_WAIT = 2'd1,
        ST_UNF_WAIT = 2'd2
    } rwin_state_e;

    localparam int ARCH_W     = 5;
    localparam int GROUP_SZ   = 8;
    localparam int WIN_STRIDE = 16;
    localparam int STRIDE_W   = $clog2(WIN_STRIDE);

endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter  int NPHYS  = 128,
    localparam int NWIN   = NPHYS / WIN_STRIDE,
    localparam int PTR_W  = $clog2(NWIN),
    localparam int PHYS_W = $clog2(NPHYS)
) (
    input  logic [PTR_W-1:0]  win_ptr,
    input  logic [ARCH_W-1:0] arch_idx,
    output logic              is_glb,
    output logic [PHYS_W-1:0] phys_idx
);

    logic [PHYS_W-1:0] base;
    logic [PHYS_W-1:0] offs;

    // Window base in physical entries; offset counts from the outgoing group.
    always_comb begin
        base     = {win_ptr, STRIDE_W'(0)};
        offs     = PHYS_W'(arch_idx - ARCH_W'(GROUP_SZ));
        is_glb   = (arch_idx < ARCH_W'(GROUP_SZ));
        phys_idx = base + offs;
    end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter  int NWIN  = 8,
    localparam int PTR_W = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             spill_done,
    input  logic             fill_done,
    output logic [PTR_W-1:0] win_ptr,
    output logic [PTR_W-1:0] free_cnt,
    output logic             ovf_trap,
    output logic             unf_trap,
    output logic             wr_allow
);

    // One window stays current and one is lost to the output/input overlap.
    localparam logic [PTR_W-1:0] FREE_INIT = PTR_W'(NWIN - 2);

    rwin_state_e state_q, state_d;
    logic        do_save, do_restore, do_spill, do_fill;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state and the operation decode
    always_comb begin
        state_d    = state_q;
        do_save    = 1'b0;
        do_restore = 1'b0;
        do_spill   = 1'b0;
        do_fill    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (save_req) begin
                    if (free_cnt == '0) state_d = ST_OVF_WAIT;
                    else                do_save = 1'b1;
                end else if (restore_req) begin
                    if (free_cnt == FREE_INIT) state_d = ST_UNF_WAIT;
                    else                       do_restore = 1'b1;
                end
            end
            ST_OVF_WAIT: begin
                if (spill_done) begin
                    state_d  = ST_RUN;
                    do_spill = 1'b1;
                end
            end
            ST_UNF_WAIT: begin
                if (fill_done) begin
                    state_d = ST_RUN;
                    do_fill = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        ovf_trap = 1'b0;
        unf_trap = 1'b0;
        wr_allow = 1'b0;
        unique case (state_q)
            ST_RUN:      wr_allow = 1'b1;
            ST_OVF_WAIT: ovf_trap = 1'b1;
            ST_UNF_WAIT: unf_trap = 1'b1;
            default:     wr_allow = 1'b0;
        endcase
    end

    // Window pointer and free-window count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_ptr  <= '0;
            free_cnt <= FREE_INIT;
        end else begin
            if (do_save) begin
                win_ptr  <= win_ptr - PTR_W'(1);
                free_cnt <= free_cnt - PTR_W'(1);
            end else if (do_restore) begin
                win_ptr  <= win_ptr + PTR_W'(1);
                free_cnt <= free_cnt + PTR_W'(1);
            end else if (do_spill) begin
                free_cnt <= free_cnt + PTR_W'(1);
            end else if (do_fill) begin
                free_cnt <= free_cnt - PTR_W'(1);
            end
        end
    end

endmodule

// File: rtl/rwin_store.sv
module rwin_store
    import rwin_pkg::*;
#(
    parameter  int DW     = 32,
    parameter  int NPHYS  = 128,
    parameter  int NRD    = 2,
    localparam int NWIN   = NPHYS / WIN_STRIDE,
    localparam int PTR_W  = $clog2(NWIN),
    localparam int PHYS_W = $clog2(NPHYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PTR_W-1:0]             win_ptr,
    input  logic [NRD-1:0][ARCH_W-1:0]   rd_idx,
    output logic [NRD-1:0][DW-1:0]       rd_data,
    input  logic                         wr_en,
    input  logic [ARCH_W-1:0]            wr_idx,
    input  logic [DW-1:0]                wr_data
);

    logic [DW-1:0] glb_q [GROUP_SZ];
    logic [DW-1:0] win_q [NPHYS];

    logic              wr_glb;
    logic [PHYS_W-1:0] wr_phys;

    rwin_map #(.NPHYS(NPHYS)) u_wr_map (
        .win_ptr (win_ptr),
        .arch_idx(wr_idx),
        .is_glb  (wr_glb),
        .phys_idx(wr_phys)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic              rd_glb;
        logic [PHYS_W-1:0] rd_phys;

        rwin_map #(.NPHYS(NPHYS)) u_rd_map (
            .win_ptr (win_ptr),
            .arch_idx(rd_idx[p]),
            .is_glb  (rd_glb),
            .phys_idx(rd_phys)
        );

        always_comb begin
            if (rd_idx[p] == '0)  rd_data[p] = '0;
            else if (rd_glb)      rd_data[p] = glb_q[rd_idx[p][2:0]];
            else                  rd_data[p] = win_q[rd_phys];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < GROUP_SZ; g++) glb_q[g] <= '0;
            for (int e = 0; e < NPHYS; e++)    win_q[e] <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            if (wr_glb) glb_q[wr_idx[2:0]] <= wr_data;
            else        win_q[wr_phys]     <= wr_data;
        end
    end

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter  int DW    = 32,
    parameter  int NPHYS = 128,
    localparam int NWIN  = NPHYS / WIN_STRIDE,
    localparam int PTR_W = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        rd_a_idx,
    output logic [DW-1:0]     rd_a_data,
    input  logic [4:0]        rd_b_idx,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic [4:0]        wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              save_req,
    input  logic              restore_req,
    input  logic              spill_done,
    input  logic              fill_done,
    output logic [PTR_W-1:0]  win_ptr,
    output logic              ovf_trap,
    output logic              unf_trap
);

    logic [PTR_W-1:0]         free_cnt;
    logic                     wr_allow;
    logic [1:0][ARCH_W-1:0]   rd_idx;
    logic [1:0][DW-1:0]       rd_data;

    assign rd_idx    = {rd_b_idx, rd_a_idx};
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .save_req   (save_req),
        .restore_req(restore_req),
        .spill_done (spill_done),
        .fill_done  (fill_done),
        .win_ptr    (win_ptr),
        .free_cnt   (free_cnt),
        .ovf_trap   (ovf_trap),
        .unf_trap   (unf_trap),
        .wr_allow   (wr_allow)
    );

    rwin_store #(.DW(DW), .NPHYS(NPHYS), .NRD(2)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .win_ptr(win_ptr),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .wr_en  (wr_en && wr_allow),
        .wr_idx (wr_idx),
        .wr_data(wr_data)
    );

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
    parameter  int DW    = 32,
    parameter  int NPHYS = 128,
    localparam int NWIN  = NPHYS / 16,
    localparam int PTR_W = $clog2(NWIN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       rd_a_idx,
    input logic [DW-1:0]    rd_a_data,
    input logic [4:0]       rd_b_idx,
    input logic [DW-1:0]    rd_b_data,
    input logic             save_req,
    input logic             restore_req,
    input logic             spill_done,
    input logic             fill_done,
    input logic [PTR_W-1:0] win_ptr,
    input logic [PTR_W-1:0] free_cnt,
    input logic             ovf_trap,
    input logic             unf_trap
);

    localparam logic [PTR_W-1:0] FREE_TOP = PTR_W'(NWIN - 2);

    logic run;
    assign run = !ovf_trap && !unf_trap;

    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));                        // R2
    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));                        // R2
    AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap && unf_trap));                                         // R5
    AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && save_req && free_cnt != '0)
        |=> (win_ptr == $past(win_ptr) - PTR_W'(1)));                     // R3
    AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !save_req && restore_req && free_cnt != FREE_TOP)
        |=> (win_ptr == $past(win_ptr) + PTR_W'(1)));                     // R4
    AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && save_req && free_cnt == '0) |=> (ovf_trap && $stable(win_ptr))); // R5
    AST_UNF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !save_req && restore_req && free_cnt == FREE_TOP)
        |=> (unf_trap && $stable(win_ptr)));                              // R7
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trap && !spill_done) |=> (ovf_trap && $stable(win_ptr)));    // R6
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trap && spill_done) |=> !ovf_trap);                          // R6
    AST_UNF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_trap && fill_done) |=> !unf_trap);                           // R7
    AST_RUN_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !save_req && !restore_req) |=> (run && $stable(win_ptr))); // R11

endmodule

bind rwin_regfile rwin_regfile_chk #(.DW(DW), .NPHYS(NPHYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .save_req   (save_req),
    .restore_req(restore_req),
    .spill_done (spill_done),
    .fill_done  (fill_done),
    .win_ptr    (win_ptr),
    .free_cnt   (free_cnt),
    .ovf_trap   (ovf_trap),
    .unf_trap   (unf_trap)
);

// File: tb/rwin_regfile_bench.sv
`timescale 1ns / 100ps
module rwin_regfile_bench;

    localparam int DW    = 32;
    localparam int NPHYS = 128;
    localparam int NWIN  = NPHYS / 16;
    localparam int PTR_W = $clog2(NWIN);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0]    rd_a_data, rd_b_data, wr_data = '0;
    logic             wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic             spill_done = 1'b0, fill_done = 1'b0;
    logic [PTR_W-1:0] win_ptr;
    logic             ovf_trap, unf_trap;

    rwin_regfile #(.DW(DW), .NPHYS(NPHYS)) u_rwin_regfile (.*);

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference model
    logic [DW-1:0] m_glb [8];
    logic [DW-1:0] m_phys [NPHYS];
    int m_ptr, m_free, m_state;   // state: 0 run, 1 overflow wait, 2 underflow wait

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] m_read(input int a);
        if (a == 0) return '0;
        if (a < 8)  return m_glb[a];
        return m_phys[(m_ptr * 16 + a - 8) % NPHYS];
    endfunction

    task automatic check_ctrl(input string req);
        chk(int'(win_ptr) == m_ptr, {req, " win_ptr"}, DW'(win_ptr), DW'(m_ptr));
        chk(ovf_trap == (m_state == 1), {req, " ovf_trap"}, DW'(ovf_trap), DW'(m_state == 1));
        chk(unf_trap == (m_state == 2), {req, " unf_trap"}, DW'(unf_trap), DW'(m_state == 2));
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 32; a++) begin
            rd_a_idx = 5'(a);
            rd_b_idx = 5'(31 - a);
            #0.2;
            chk(rd_a_data == m_read(a), {req, " port A"}, rd_a_data, m_read(a));
            chk(rd_b_data == m_read(31 - a), {req, " port B"}, rd_b_data, m_read(31 - a));
        end
    endtask

    // Drive at negedge, model at posedge, outputs settled at next negedge.
    task automatic step(input bit sv, input bit rs, input bit sp, input bit fl,
                        input bit we, input int wi, input logic [DW-1:0] wd);
        save_req = sv; restore_req = rs; spill_done = sp; fill_done = fl;
        wr_en = we; wr_idx = 5'(wi); wr_data = wd;
        @(posedge clk);
        if (m_state == 0) begin
            if (we && wi != 0) begin
                if (wi < 8) m_glb[wi] = wd;
                else        m_phys[(m_ptr * 16 + wi - 8) % NPHYS] = wd;
            end
            if (sv) begin
                if (m_free == 0) m_state = 1;
                else begin m_ptr = (m_ptr + NWIN - 1) % NWIN; m_free--; end
            end else if (rs) begin
                if (m_free == NWIN - 2) m_state = 2;
                else begin m_ptr = (m_ptr + 1) % NWIN; m_free++; end
            end
        end else if (m_state == 1) begin
            if (sp) begin m_state = 0; m_free++; end
        end else begin
            if (fl) begin m_state = 0; m_free--; end
        end
        @(negedge clk);
        save_req = 0; restore_req = 0; spill_done = 0; fill_done = 0; wr_en = 0;
    endtask

    function automatic logic [DW-1:0] pat(input int s, input int a);
        return 32'hA500_0000 | DW'(s << 8) | DW'(a);
    endfunction

    task automatic fill_window(input int s);
        for (int a = 0; a < 32; a++) step(0, 0, 0, 0, 1, a, pat(s, a));
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            report();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] outs [8];
        for (int g = 0; g < 8; g++) m_glb[g] = '0;
        for (int e = 0; e < NPHYS; e++) m_phys[e] = '0;
        m_ptr = 0; m_free = NWIN - 2; m_state = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check_ctrl("R9");
        check_all("R9");

        // R1, R2: write every index in window 0, including index 0
        fill_window(1);
        check_all("R1/R2 window0");
        chk(rd_a_data != 32'hA500_0100 || rd_a_idx != 0, "R2 zero write", rd_a_data, '0);

        // R3: six calls, alias of outgoing onto incoming, fresh writes each level
        for (int k = 2; k <= NWIN - 1; k++) begin
            for (int a = 8; a < 16; a++) outs[a - 8] = m_read(a);
            step(1, 0, 0, 0, 0, 0, '0);
            check_ctrl("R3 save");
            for (int a = 24; a < 32; a++) begin
                rd_a_idx = 5'(a); #0.2;
                chk(rd_a_data == outs[a - 24], "R3 alias", rd_a_data, outs[a - 24]);
            end
            check_all("R3 window");
            for (int a = 8; a < 24; a++) step(0, 0, 0, 0, 1, a, pat(k, a));
        end

        // R5: no free window left
        step(1, 0, 0, 0, 0, 0, '0);
        check_ctrl("R5 overflow");

        // R6: everything ignored while overflow pending
        step(0, 0, 0, 0, 1, 17, 32'hDEAD_0017);
        step(0, 0, 0, 0, 1, 3, 32'hDEAD_0003);
        step(1, 0, 0, 0, 0, 0, '0);
        step(0, 1, 0, 0, 0, 0, '0);
        step(0, 0, 0, 1, 0, 0, '0);
        check_ctrl("R6 held");
        check_all("R6 contents");
        step(0, 0, 1, 0, 0, 0, '0);
        check_ctrl("R6 spill");

        // R11: done strobes in run state do nothing
        step(0, 0, 1, 0, 0, 0, '0);
        step(0, 0, 0, 1, 0, 0, '0);
        check_ctrl("R11");
        step(1, 0, 0, 0, 0, 0, '0);
        check_ctrl("R6 one window freed");
        step(1, 0, 0, 0, 0, 0, '0);
        check_ctrl("R5 again");
        step(0, 0, 1, 0, 0, 0, '0);
        check_ctrl("R6 spill2");

        // R8: same-cycle read returns old value, write visible after edge
        rd_a_idx = 5'd20; rd_b_idx = 5'd5;
        wr_en = 1; wr_idx = 5'd20; wr_data = 32'h1234_5678;
        #0.2;
        chk(rd_a_data == m_read(20), "R8 old value", rd_a_data, m_read(20));
        chk(rd_b_data == m_read(5), "R8 port B", rd_b_data, m_read(5));
        step(0, 0, 0, 0, 1, 20, 32'h1234_5678);
        rd_a_idx = 5'd20; #0.2;
        chk(rd_a_data == 32'h1234_5678, "R8 new value", rd_a_data, 32'h1234_5678);

        // R4: returns up to the underflow point
        while (m_free != NWIN - 2) begin
            step(0, 1, 0, 0, 0, 0, '0);
            check_ctrl("R4 restore");
            check_all("R4 window");
        end

        // R7: underflow, then fill
        step(0, 1, 0, 0, 0, 0, '0);
        check_ctrl("R7 underflow");
        step(0, 0, 0, 0, 1, 9, 32'hDEAD_0009);
        step(0, 0, 1, 0, 0, 0, '0);
        check_ctrl("R7 held");
        check_all("R7 contents");
        step(0, 0, 0, 1, 0, 0, '0);
        check_ctrl("R7 fill");
        step(0, 1, 0, 0, 0, 0, '0);
        check_ctrl("R7 restore after fill");
        check_all("R7 window");

        // R10: save and restore together act as save
        step(1, 1, 0, 0, 0, 0, '0);
        check_ctrl("R10");
        check_all("R10 window");

        done = 1'b1;
        report();
        $finish;
    end

endmodule